// File: doc/BRIEF.md
# DC-Only Dequantize and Pixel Reconstruction

This block rebuilds a square luma block of 4x4 or 8x8 pixels when the only non-zero residual coefficient is the DC term. When `start` is accepted, the block captures one signed 16-bit quantized DC coefficient, a 16-bit scale entry, a 16-bit weight entry, a left-shift amount (QP divided by six), a start index and an alternate DC value that has already been dequantized. Over the next two cycles it turns these into one signed residual and holds it in a register.

Prediction rows then enter one per cycle on a valid/ready stream. Each pixel of every row receives the same residual, and the sum is clipped to the 8-bit pixel range. Reconstructed rows leave through a registered valid/ready stream. A one-cycle `done` pulse marks the completion of the block, which makes it simple to chain blocks one after another.

Top module: `dc_recon`

## Requirements
- R1: In 4x4 mode with a start index other than 1, the DC value is computed as follows. Take the low 16 bits of scale*weight and read them as a signed value P. Form the 32-bit product coef*P and shift it left by `qp_shift`, wrapping modulo 2^32. Add 8, shift arithmetically right by 4, and saturate the result to the range -32768..32767.
- R2: In 8x8 mode the DC value is computed as in R1, except that 32 is added and the arithmetic right shift is by 6.
- R3: In 4x4 mode, a start index of 1 makes `alt_dc` the DC value directly and leaves coef, scale, weight and shift without effect. In 8x8 mode the start index and `alt_dc` have no effect.
- R4: The residual is floor((DC + 32) / 64), taken over the signed 16-bit DC value.
- R5: Each output pixel is clip(pred + residual) to the range 0..255. Pixel c of a row occupies bits 8c+7:8c.
- R6: A 4x4 block produces exactly 4 output rows, and an 8x8 block produces exactly 8. Every pixel of the block uses the same residual. In 4x4 mode only pixels 0..3 are valid, and bits 63:32 of `out_row` are zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_row` and `out_valid` hold steady and `pred_ready` is low.
- R8: `done` is high for exactly one cycle. That cycle is the first one after the clock edge on which the block's last row was handed off at the output.
- R9: `start` is ignored while a block is in progress, and such a pulse does not change the residual in use. `pred_ready` stays low until the residual is ready, which is the second cycle after `start` is accepted.
- R10: After reset, `out_valid`, `done` and `pred_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; accepted only when idle |
| blk8 | input | 1 | 1 selects 8x8, 0 selects 4x4 |
| first_idx | input | 5 | Start index; value 1 selects the alternate DC in 4x4 mode |
| coef | input | 16 | Signed quantized DC coefficient |
| scale | input | 16 | Dequantization scale entry |
| weight | input | 16 | Weighting entry |
| qp_shift | input | 4 | Left shift amount (QP/6) |
| alt_dc | input | 16 | Signed pre-dequantized DC value |
| pred_valid | input | 1 | Prediction row valid |
| pred_ready | output | 1 | Prediction row accepted this cycle when valid |
| pred_row | input | 64 | Eight unsigned 8-bit prediction pixels |
| out_valid | output | 1 | Reconstructed row valid |
| out_ready | input | 1 | Sink accepts the row |
| out_row | output | 64 | Eight reconstructed pixels |
| done | output | 1 | One-cycle pulse after the last row is handed off |

## Verification
The assertions assume that the sink's `out_ready` is free-running. They also assume that the source never sends more prediction rows than the block size, which the sequencer enforces anyway by dropping `pred_ready` once the last row is in. The row-count property treats each start as one whole block, so the stimulus waits for `done` before it sends the next start. The only exception is the deliberate start pulse in the middle of a block, which must be ignored. Backpressure tests stall the output every third cycle and leave gaps on the input every other cycle, so that both the stall-hold rule and the ready coupling are exercised.

// File: rtl/dc_recon_pkg.sv
package dc_recon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_RUN,
    ST_DRAIN
  } seq_state_t;

  localparam int DC_W   = 16;
  localparam int OUT_SH = 6;
  localparam int SH_4X4 = 4;
  localparam int SH_8X8 = 6;
endpackage

// File: rtl/dc_dequant.sv
module dc_dequant
  import dc_recon_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int QP_W   = 4,
  parameter int IDX_W  = 5,
  parameter int RES_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     finish,
  input  logic                     is8,
  input  logic [IDX_W-1:0]         first_idx,
  input  logic signed [COEF_W-1:0] coef,
  input  logic [COEF_W-1:0]        scale,
  input  logic [COEF_W-1:0]        weight,
  input  logic [QP_W-1:0]          qp_shift,
  input  logic signed [COEF_W-1:0] alt_dc,
  output logic signed [RES_W-1:0]  resid
);
  localparam int PROD_W = 2 * COEF_W;
  localparam int AW     = PROD_W + 1;
  localparam logic signed [AW-1:0] SAT_HI =
    {{(AW-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [AW-1:0] SAT_LO =
    {{(AW-COEF_W+1){1'b1}}, {(COEF_W-1){1'b0}}};
  localparam logic signed [AW-1:0] ADD_4 = AW'(1) <<< (SH_4X4 - 1);
  localparam logic signed [AW-1:0] ADD_8 = AW'(1) <<< (SH_8X8 - 1);
  localparam logic signed [COEF_W:0] ADD_OUT = (COEF_W+1)'(1) <<< (OUT_SH - 1);

  // stage 1: product and left shift
  logic [PROD_W-1:0]        sw_full;
  logic signed [COEF_W-1:0] sw_trunc;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;

  always_comb begin
    sw_full  = PROD_W'(scale) * PROD_W'(weight);
    sw_trunc = $signed(sw_full[COEF_W-1:0]);
    prod     = PROD_W'(coef) * PROD_W'(sw_trunc);
    prod_sh  = prod <<< qp_shift;
  end

  logic signed [PROD_W-1:0] acc_q;
  logic                     is8_q;
  logic                     use_alt_q;
  logic signed [COEF_W-1:0] alt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      is8_q     <= 1'b0;
      use_alt_q <= 1'b0;
      alt_q     <= '0;
    end else if (load) begin
      acc_q     <= prod_sh;
      is8_q     <= is8;
      use_alt_q <= !is8 && (first_idx == IDX_W'(1));
      alt_q     <= alt_dc;
    end
  end

  // stage 2: rounding shift, saturation, residual rounding
  logic signed [AW-1:0]     rnd;
  logic signed [AW-1:0]     shr;
  logic signed [COEF_W-1:0] dc_sat;
  logic signed [COEF_W-1:0] dc_sel;
  logic signed [COEF_W:0]   rsum;
  logic signed [RES_W-1:0]  resid_next;

  always_comb begin
    rnd = {acc_q[PROD_W-1], acc_q} + (is8_q ? ADD_8 : ADD_4);
    shr = is8_q ? (rnd >>> SH_8X8) : (rnd >>> SH_4X4);
    if (shr > SAT_HI)      dc_sat = SAT_HI[COEF_W-1:0];
    else if (shr < SAT_LO) dc_sat = SAT_LO[COEF_W-1:0];
    else                   dc_sat = shr[COEF_W-1:0];
    dc_sel     = use_alt_q ? alt_q : dc_sat;
    rsum       = {dc_sel[COEF_W-1], dc_sel} + ADD_OUT;
    resid_next = RES_W'(rsum >>> OUT_SH);
  end

  always_ff @(posedge clk) begin
    if (rst)         resid <= '0;
    else if (finish) resid <= resid_next;
  end
endmodule

// File: rtl/dc_row_clip.sv
module dc_row_clip #(
  parameter int PIX_W  = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 4,
  parameter int RES_W  = 11
) (
  input  logic signed [RES_W-1:0] resid,
  input  logic                    narrow,
  input  logic [WIDE*PIX_W-1:0]   row_in,
  output logic [WIDE*PIX_W-1:0]   row_out
);
  localparam int BASE_W = (RES_W > PIX_W + 1) ? RES_W : PIX_W + 1;
  localparam int SUM_W  = BASE_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  for (genvar c = 0; c < WIDE; c++) begin : g_lane
    logic signed [SUM_W-1:0] sum;
    logic [PIX_W-1:0]        clip;
    always_comb begin
      sum = SUM_W'(resid) + SUM_W'($signed({1'b0, row_in[c*PIX_W +: PIX_W]}));
      if (sum[SUM_W-1])  clip = '0;
      else if (sum > MAXV) clip = '1;
      else               clip = sum[PIX_W-1:0];
    end
    if (c < NARROW) begin : g_always
      assign row_out[c*PIX_W +: PIX_W] = clip;
    end else begin : g_wide_only
      assign row_out[c*PIX_W +: PIX_W] = narrow ? '0 : clip;
    end
  end
endmodule

// File: rtl/dc_recon.sv
module dc_recon
  import dc_recon_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 4,
  parameter int COEF_W = 16,
  parameter int QP_W   = 4,
  parameter int IDX_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   blk8,
  input  logic [IDX_W-1:0]       first_idx,
  input  logic [COEF_W-1:0]      coef,
  input  logic [COEF_W-1:0]      scale,
  input  logic [COEF_W-1:0]      weight,
  input  logic [QP_W-1:0]        qp_shift,
  input  logic [COEF_W-1:0]      alt_dc,
  input  logic                   pred_valid,
  output logic                   pred_ready,
  input  logic [WIDE*PIX_W-1:0]  pred_row,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WIDE*PIX_W-1:0]  out_row,
  output logic                   done
);
  localparam int RES_W = COEF_W - OUT_SH + 1;
  localparam int CNT_W = (WIDE > 1) ? $clog2(WIDE) : 1;

  seq_state_t               st;
  logic                     blk8_q;
  logic [CNT_W-1:0]         row_cnt;
  logic                     last_row;
  logic                     start_fire;
  logic                     pred_fire;
  logic                     out_fire;
  logic signed [RES_W-1:0]  resid;
  logic [WIDE*PIX_W-1:0]    clip_row;

  assign start_fire = start && (st == ST_IDLE);
  assign pred_ready = (st == ST_RUN) && (!out_valid || out_ready);
  assign pred_fire  = pred_valid && pred_ready;
  assign out_fire   = out_valid && out_ready;
  assign last_row   = row_cnt == (blk8_q ? CNT_W'(WIDE - 1) : CNT_W'(NARROW - 1));

  dc_dequant #(
    .COEF_W(COEF_W), .QP_W(QP_W), .IDX_W(IDX_W), .RES_W(RES_W)
  ) dq_i (
    .clk(clk), .rst(rst),
    .load(start_fire), .finish(st == ST_CALC),
    .is8(blk8), .first_idx(first_idx),
    .coef($signed(coef)), .scale(scale), .weight(weight),
    .qp_shift(qp_shift), .alt_dc($signed(alt_dc)),
    .resid(resid)
  );

  dc_row_clip #(
    .PIX_W(PIX_W), .WIDE(WIDE), .NARROW(NARROW), .RES_W(RES_W)
  ) clip_i (
    .resid(resid), .narrow(!blk8_q),
    .row_in(pred_row), .row_out(clip_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      blk8_q    <= 1'b0;
      row_cnt   <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_fire) out_valid <= 1'b0;
      if (pred_fire) begin
        out_valid <= 1'b1;
        out_row   <= clip_row;
      end
      case (st)
        ST_IDLE: if (start_fire) begin
          blk8_q  <= blk8;
          row_cnt <= '0;
          st      <= ST_CALC;
        end
        ST_CALC: st <= ST_RUN;
        ST_RUN: if (pred_fire) begin
          row_cnt <= row_cnt + 1'b1;
          if (last_row) st <= ST_DRAIN;
        end
        ST_DRAIN: if (out_fire) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_recon_chk.sv
module dc_recon_chk #(
  parameter int PIX_W  = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pred_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WIDE*PIX_W-1:0] out_row,
  input logic                  done,
  input logic                  wide_q
);
  localparam int RC_W = $clog2(WIDE + 1) + 1;
  logic [RC_W-1:0] rows_seen;

  always_ff @(posedge clk) begin
    if (rst || done) rows_seen <= '0;
    else if (out_valid && out_ready) rows_seen <= rows_seen + 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_row));

  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !pred_ready);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(out_valid && out_ready));

  p_rows_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> rows_seen == (wide_q ? RC_W'(WIDE) : RC_W'(NARROW)));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !wide_q |-> out_row[WIDE*PIX_W-1:NARROW*PIX_W] == '0);

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !done && !pred_ready);
endmodule

bind dc_recon dc_recon_chk #(.PIX_W(PIX_W), .WIDE(WIDE), .NARROW(NARROW)) chk_i (
  .clk(clk), .rst(rst), .pred_ready(pred_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_row(out_row), .done(done), .wide_q(blk8_q)
);

// File: tb/dc_recon_tb_top.sv
module dc_recon_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, blk8, pred_valid, out_ready;
  logic [4:0]  first_idx;
  logic [15:0] coef, scale, weight, alt_dc;
  logic [3:0]  qp_shift;
  logic [63:0] pred_row;
  logic        pred_ready, out_valid, done;
  logic [63:0] out_row;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_recon dut_i (
    .clk(clk), .rst(rst), .start(start), .blk8(blk8), .first_idx(first_idx),
    .coef(coef), .scale(scale), .weight(weight), .qp_shift(qp_shift),
    .alt_dc(alt_dc), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_row(pred_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .done(done)
  );

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  function automatic int exp_res(int c, int s, int w, int qp, bit is8, int idx, int alt);
    int dc, p16, m32;
    longint r;
    if (!is8 && idx == 1) dc = alt;
    else begin
      p16 = (s * w) & 32'hFFFF;
      if (p16 > 32767) p16 -= 65536;
      m32 = c * p16;
      m32 = m32 <<< qp;
      r = is8 ? ((longint'(m32) + 32) >>> 6) : ((longint'(m32) + 8) >>> 4);
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      dc = int'(r);
    end
    return (dc + 32) >>> 6;
  endfunction

  function automatic logic [63:0] gen_row(int kind, int seed, int r);
    logic [63:0] v;
    for (int c = 0; c < 8; c++) begin
      case (kind)
        1: v[c*8 +: 8] = 8'd255;
        2: v[c*8 +: 8] = 8'd0;
        default: v[c*8 +: 8] = 8'((seed + 37*r + 29*c) & 255);
      endcase
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_row(logic [63:0] p, int res, bit is8);
    logic [63:0] v = '0;
    int s;
    for (int c = 0; c < (is8 ? 8 : 4); c++) begin
      s = int'(p[c*8 +: 8]) + res;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      v[c*8 +: 8] = 8'(s);
    end
    return v;
  endfunction

  task automatic run_block(string req, int c, int s, int w, int qp, bit is8,
                           int idx, int alt, int kind, int seed, bit stall, bit restart);
    int res = exp_res(c, s, w, qp, is8, idx, alt);
    int rows = is8 ? 8 : 4;
    int k_in = 0, k_out = 0, dones = 0;
    logic [63:0] sent [8];
    logic [63:0] held;
    bit was_stalled = 0;
    @(negedge clk);
    start = 1; blk8 = is8; first_idx = 5'(idx); coef = 16'(c); scale = 16'(s);
    weight = 16'(w); qp_shift = 4'(qp); alt_dc = 16'(alt);
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 200 && dones == 0; cyc++) begin
      if (restart && cyc == 3) begin
        start = 1; coef = 16'(c ^ 16'h2A5); alt_dc = 16'(alt + 999); qp_shift = 4'(qp + 3);
      end else start = 0;
      if (cyc == 0) chk("R9", "pred_ready before residual", 64'(pred_ready), 64'd0);
      if (was_stalled) begin
        chk("R7", "row held under stall", out_row, held);
        was_stalled = 0;
      end
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (done) begin
        dones++;
        chk(req, "rows before done (R8)", 64'(k_out), 64'(rows));
      end
      if (out_valid && out_ready) begin
        chk(req, "row value (R5/R6)", out_row, exp_row(sent[k_out], res, is8));
        k_out++;
      end else if (out_valid) begin
        held = out_row;
        was_stalled = 1;
      end
      pred_valid = (k_in < rows) && (!stall || cyc % 2 == 0);
      pred_row = gen_row(kind, seed, k_in);
      #1;
      if (out_valid && !out_ready)
        chk("R7", "pred_ready under stall", 64'(pred_ready), 64'd0);
      if (pred_valid && pred_ready) begin
        sent[k_in] = pred_row;
        k_in++;
      end
      @(negedge clk);
      pred_valid = 0;
    end
    start = 0;
    chk("R8", "done pulses", 64'(dones), 64'd1);
    #1;
    chk("R8", "done low after pulse", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    rst = 1; start = 0; blk8 = 0; first_idx = 0; coef = 0; scale = 0; weight = 0;
    qp_shift = 0; alt_dc = 0; pred_valid = 0; pred_row = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R10", "out_valid", 64'(out_valid), 64'd0);
    chk("R10", "done", 64'(done), 64'd0);
    chk("R10", "pred_ready", 64'(pred_ready), 64'd0);
    pred_valid = 1;
    @(negedge clk);
    chk("R9", "idle pred_ready", 64'(pred_ready), 64'd0);
    pred_valid = 0;
  endtask

  task automatic t_dc4;       run_block("R1", 40, 10, 16, 1, 0, 0, 0, 0, 3, 0, 0); endtask
  task automatic t_dc8;       run_block("R2", -23, 20, 16, 3, 1, 0, 0, 0, 71, 0, 0); endtask
  task automatic t_intra4;    run_block("R3", 9000, 16, 16, 5, 0, 1, -700, 0, 140, 0, 0); endtask
  task automatic t_idx8;      run_block("R3", 17, 25, 16, 2, 1, 1, 30000, 0, 9, 0, 0); endtask
  task automatic t_trunc;     run_block("R1", 3, 300, 300, 0, 0, 0, 0, 0, 200, 0, 0); endtask
  task automatic t_negprod;   run_block("R4", 2, 200, 200, 0, 1, 0, 0, 0, 50, 0, 0); endtask
  task automatic t_sat_hi;    run_block("R5", 32767, 16, 16, 4, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic t_sat_lo;    run_block("R5", -32768, 16, 16, 4, 1, 0, 0, 0, 90, 0, 0); endtask
  task automatic t_alt_floor; run_block("R4", 0, 0, 0, 0, 0, 1, -33, 2, 0, 0, 0); endtask
  task automatic t_stall;     run_block("R7", 100, 13, 16, 2, 1, 0, 0, 0, 17, 1, 0); endtask
  task automatic t_restart;   run_block("R9", -61, 18, 16, 2, 1, 0, 0, 0, 33, 1, 1); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_dc4();
    t_dc8();
    t_intra4();
    t_idx8();
    t_trunc();
    t_negprod();
    t_sat_hi();
    t_sat_lo();
    t_alt_floor();
    t_stall();
    t_restart();
    t_dc4();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule